// File: doc/BRIEF.md
# Load Value Forwarding Queue

This block connects two redundant copies of a program that run on the same core, one ahead of the other. Only the leading copy reads the data cache. Each time the leading copy retires a load, it writes the load address and the value it received into this queue. The trailing copy never reads the cache. It takes its load results from the queue, one at a time, strictly in program order, and it does not speculate. Both copies therefore see identical memory inputs.

At each pop the trailing copy also presents the address it computed for the load. The block compares that address with the stored one. A difference means a fault inside the replicated logic. It raises a flag that stays set until reset, and the stored value is still delivered so that the trailing copy keeps running.

The depth is a parameter; 16 and 64 entries are the sizes of interest. A full queue raises a stall that holds back retirement of leading loads. A pop on an empty queue reports a wait until a value arrives.

Top module: `ldfwd_queue`

## Requirements
- R1: While reset is asserted and directly after it is released, the queue is empty: `stall` is 0, `fault` is 0, and a pop request reports `pop_wait`.
- R2: Values leave in the same order in which they were accepted. A pop request with at least one stored entry asserts `pop_valid` in the same cycle, presents the oldest entry's value on `pop_data`, and removes that entry at the clock edge.
- R3: `stall` is 1 exactly when DEPTH entries are held. A push offered while full and without a same-cycle pop is dropped and does not overwrite any stored entry.
- R4: A pop request on an empty queue with no push in the same cycle asserts `pop_wait`, keeps `pop_valid` at 0, and consumes nothing.
- R5: When a pop is taken and `pop_addr` differs from the stored address, `fault` rises at the next clock edge and stays 1 until reset. The stored value is still presented on `pop_data`.
- R6: Pops whose `pop_addr` equals the stored address leave `fault` unchanged.
- R7: When the queue is full, a push and a pop in the same cycle are both accepted. The queue stays full and order is kept.
- R8: When the queue is empty, a push and a pop in the same cycle are both accepted. The pushed value appears on `pop_data` in that cycle, the pushed address is the one compared, and the queue stays empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Leading copy retires a load this cycle |
| push_addr | input | AW | Address of the retired leading load |
| push_data | input | DW | Value returned to the leading load |
| stall | output | 1 | Queue full; hold leading load retirement |
| pop_req | input | 1 | Trailing copy requests its next load value |
| pop_addr | input | AW | Address computed by the trailing copy |
| pop_valid | output | 1 | A value is delivered and consumed this cycle |
| pop_data | output | DW | Value delivered to the trailing copy |
| pop_wait | output | 1 | Request made on an empty queue; retry later |
| fault | output | 1 | Sticky address mismatch indication |

## Verification
A wrong occupancy count shows as `stall` asserting early or late, or as `pop_wait` appearing while data is held. The bench compares both in the same cycle in which they are driven. A pointer that skips or repeats shows on the very next pop as a value out of order, which the scoreboard catches at once. A comparator or sticky-flag error shows on `fault` one clock edge after the pop concerned. The flag is checked after every edge, so a flag that rises falsely or clears itself is reported within a cycle.

// File: rtl/ldfwd_pkg.sv
package ldfwd_pkg;
  // What a pop request does in the current cycle
  typedef enum logic [1:0] {
    POP_IDLE   = 2'd0,  // no request
    POP_HIT    = 2'd1,  // served from storage
    POP_BYPASS = 2'd2,  // served by the same-cycle push (queue empty)
    POP_WAIT   = 2'd3   // empty queue, nothing to forward
  } pop_kind_e;
endpackage

// File: rtl/ldfwd_ctrl.sv
module ldfwd_ctrl
  import ldfwd_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic          pop_req,
  output pop_kind_e     pop_kind,
  output logic          wr_en,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic          full
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic          empty, hit;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  always_comb begin
    if (!pop_req)        pop_kind = POP_IDLE;
    else if (!empty)     pop_kind = POP_HIT;
    else if (push_valid) pop_kind = POP_BYPASS;
    else                 pop_kind = POP_WAIT;
  end

  assign hit   = (pop_kind == POP_HIT);
  // a full queue takes a push only when a stored entry leaves in the same cycle;
  // a bypassed push never reaches storage
  assign wr_en = push_valid && (pop_kind != POP_BYPASS) && (!full || hit);

  always_comb begin
    wr_d  = wr_en ? bump(wr_q) : wr_q;
    rd_d  = hit   ? bump(rd_q) : rd_q;
    cnt_d = cnt_q + CW'(wr_en) - CW'(hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      wr_q  <= wr_d;
      rd_q  <= rd_d;
    end
  end

  assign wr_ptr = wr_q;
  assign rd_ptr = rd_q;

  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !hit) |=> full);
  a_r4_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push_valid) |=> empty);
  a_r8_bypass_keeps_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_kind == POP_BYPASS) |=> empty);
  a_r2_head_advances: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (rd_q != $past(rd_q)) || (DEPTH == 1));
endmodule

// File: rtl/ldfwd_store.sv
module ldfwd_store #(
  parameter int DEPTH = 16,
  parameter int W     = 96,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [PW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem_q [DEPTH];

  // data flops carry no reset; occupancy in the controller guards every read
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic sel;
    assign sel = we && (waddr == PW'(g));
    always_ff @(posedge clk) begin
      if (sel) mem_q[g] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/ldfwd_check.sv
module ldfwd_check #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [AW-1:0] ref_addr,
  input  logic [AW-1:0] trail_addr,
  output logic          fault
);
  logic fault_q, fault_d, miss;

  assign miss    = take && (ref_addr != trail_addr);
  assign fault_d = fault_q || miss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  assign fault = fault_q;

  a_r5_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> fault_q);
  a_r5_fault_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (ref_addr != trail_addr)) |=> fault_q);
  a_r6_match_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_q && !(take && (ref_addr != trail_addr))) |=> !fault_q);
endmodule

// File: rtl/ldfwd_queue.sv
module ldfwd_queue
  import ldfwd_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int DW    = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  output logic          stall,
  input  logic          pop_req,
  input  logic [AW-1:0] pop_addr,
  output logic          pop_valid,
  output logic [DW-1:0] pop_data,
  output logic          pop_wait,
  output logic          fault
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = AW + DW;

  pop_kind_e     kind;
  logic          wr_en, full, take;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [EW-1:0] stored, head;

  ldfwd_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .pop_req    (pop_req),
    .pop_kind   (kind),
    .wr_en      (wr_en),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .full       (full)
  );

  ldfwd_store #(.DEPTH(DEPTH), .W(EW)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_ptr),
    .wdata ({push_addr, push_data}),
    .raddr (rd_ptr),
    .rdata (stored)
  );

  assign head = (kind == POP_BYPASS) ? {push_addr, push_data} : stored;
  assign take = (kind == POP_HIT) || (kind == POP_BYPASS);

  ldfwd_check #(.AW(AW)) u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .ref_addr   (head[EW-1:DW]),
    .trail_addr (pop_addr),
    .fault      (fault)
  );

  assign stall     = full;
  assign pop_valid = take;
  assign pop_data  = head[DW-1:0];
  assign pop_wait  = (kind == POP_WAIT);

  a_r4_wait_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_wait && pop_valid));
  a_r3_stall_blocks_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !pop_req) |=> stall);
  a_r4_wait_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    pop_wait |-> pop_req);
endmodule

// File: tb/ldfwd_queue_test.sv
`timescale 1ns/100ps
module ldfwd_queue_test;
  localparam int DEPTH = 16;
  localparam int AW    = 32;
  localparam int DW    = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          push_valid, pop_req;
  logic [AW-1:0] push_addr, pop_addr;
  logic [DW-1:0] push_data;
  logic          stall, pop_valid, pop_wait, fault;
  logic [DW-1:0] pop_data;

  always #2.5 clk = ~clk;

  ldfwd_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_addr(push_addr), .push_data(push_data),
    .stall(stall),
    .pop_req(pop_req), .pop_addr(pop_addr),
    .pop_valid(pop_valid), .pop_data(pop_data), .pop_wait(pop_wait),
    .fault(fault)
  );

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } ent_t;
  ent_t sbq[$];
  int   n_cmp = 0, n_bad = 0;
  logic fault_exp = 1'b0;
  bit   done = 1'b0;

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] mk_a(int i);
    return 32'h0001_0000 + AW'(i * 8);
  endfunction
  function automatic logic [DW-1:0] mk_d(int i);
    return {32'hC0DE_0000 + 32'(i), 32'(i * 32'h9E37)};
  endfunction

  // driver and monitor for one cycle: drive at negedge, compare before the edge,
  // update the scoreboard at the edge, compare the flag after it
  task automatic step(bit pv, int idx, bit pr, bit bad);
    int   sz;
    bit   have, fire, pacc;
    ent_t e;
    string tag;
    @(negedge clk);
    sz   = sbq.size();
    have = 1'b0;
    e.a  = '0;
    e.d  = '0;
    if (sz > 0) begin e = sbq[0]; have = 1'b1; end
    else if (pv) begin e.a = mk_a(idx); e.d = mk_d(idx); have = 1'b1; end
    push_valid = pv;
    push_addr  = mk_a(idx);
    push_data  = mk_d(idx);
    pop_req    = pr;
    pop_addr   = bad ? (e.a ^ 32'h4) : e.a;
    #1;
    chk(stall == (sz == DEPTH), "R3", DW'(stall), DW'(sz == DEPTH));
    chk(pop_wait == (pr && !have), "R4", DW'(pop_wait), DW'(pr && !have));
    chk(pop_valid == (pr && have), "R2", DW'(pop_valid), DW'(pr && have));
    fire = pr && have;
    if (fire) begin
      tag = (sz == 0) ? "R8" : ((sz == DEPTH) ? "R7" : "R2");
      chk(pop_data == e.d, tag, pop_data, e.d);
    end
    pacc = pv && ((sz < DEPTH) || fire);
    if (fire && bad) fault_exp = 1'b1;
    @(posedge clk);
    if (fire && sz > 0) void'(sbq.pop_front());
    if (pacc && !(fire && sz == 0)) sbq.push_back(e_of(idx));
    #1;
    chk(fault == fault_exp, fault_exp ? "R5" : "R6", DW'(fault), DW'(fault_exp));
  endtask

  function automatic ent_t e_of(int i);
    ent_t x;
    x.a = mk_a(i);
    x.d = mk_d(i);
    return x;
  endfunction

  initial begin
    rst_n = 1'b0; push_valid = 1'b0; pop_req = 1'b0;
    push_addr = '0; push_data = '0; pop_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    pop_req = 1'b1;
    #1;
    chk(stall == 1'b0 && fault == 1'b0, "R1", DW'({stall, fault}), '0);
    rst_n = 1'b1;
    #1;
    chk(pop_wait == 1'b1, "R1", DW'(pop_wait), DW'(1));
    chk(pop_valid == 1'b0, "R1", DW'(pop_valid), '0);
    pop_req = 1'b0;

    // R2 R6: short burst, in-order pops with matching addresses
    for (int i = 0; i < 5; i++) step(1'b1, i, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 0, 1'b1, 1'b0);

    // R3 R7: fill, drop an extra push, push and pop while full, drain
    for (int i = 100; i < 100 + DEPTH; i++) step(1'b1, i, 1'b0, 1'b0);
    step(1'b1, 900, 1'b0, 1'b0);
    step(1'b1, 901, 1'b1, 1'b0);
    step(1'b1, 902, 1'b1, 1'b0);
    for (int i = 0; i < DEPTH; i++) step(1'b0, 0, 1'b1, 1'b0);
    // R4: request on empty queue waits and consumes nothing
    step(1'b0, 0, 1'b1, 1'b0);
    step(1'b0, 0, 1'b1, 1'b0);

    // R8: push and pop together on an empty queue
    for (int i = 200; i < 203; i++) step(1'b1, i, 1'b1, 1'b0);
    step(1'b0, 0, 1'b1, 1'b0);

    // mixed traffic
    for (int i = 0; i < 400; i++)
      step((i % 3) != 0 || (i % 50) < 25, 300 + i, (i % 5) != 1 && (i % 50) >= 10, 1'b0);
    while (sbq.size() > 0) step(1'b0, 0, 1'b1, 1'b0);

    // R5: mismatched trailing address flags a fault, value still delivered, flag sticks
    step(1'b1, 800, 1'b0, 1'b0);
    step(1'b1, 801, 1'b0, 1'b0);
    step(1'b0, 0, 1'b1, 1'b1);
    step(1'b0, 0, 1'b1, 1'b0);
    step(1'b0, 0, 1'b0, 1'b0);
    // R5: bypass path also compares the pushed address
    step(1'b1, 810, 1'b1, 1'b1);
    step(1'b0, 0, 1'b0, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule